// File: doc/BRIEF.md
# Two-Requester Preemptive Memory Arbiter

This block shares one memory command path between a streaming DMA requester and a processor requester. Both are 32-bit word ports. The DMA requester asks for long transfers made of whole sectors. The sector length in words is a run-time configuration input, so every DMA transfer covers a count of sectors times that length. The DMA requester can hold back its data with a pause input at any word, including part-way through a sector. The processor requester asks for short transfers: reads of one or eight words, or writes of one word. Any other processor request is refused.

The arbiter hands the command path out one word beat at a time. For each beat it drives a grant line, the word address, the direction and the number of words left in the current transfer. A downstream sequencer takes each beat with a ready signal. A processor request always wins. It takes the path away from a DMA transfer whether that transfer is moving or paused. While the processor transfer runs, the DMA position and remaining count are kept, and the DMA transfer then carries on from exactly that word. A beat that has been offered but not yet taken is never withdrawn. A new DMA transfer can be accepted in the same cycle as the last beat of the previous one, so chained DMA transfers leave no gap.

Top module: `pri_mem_arb`

## Requirements
- R1: After reset, `cmd_valid`, `gnt_cpu` and `gnt_dma` are 0. With no requests, `cpu_ack`, `cpu_rej` and `dma_ack` are 0.
- R2: A processor read (`cpu_write`=0) with `cpu_len` of 1 or 8 is acknowledged by `cpu_ack` in the cycle it is taken. From the next cycle it issues `cpu_len` beats with `gnt_cpu`=1, at consecutive word addresses from `cpu_addr`, with `cmd_len` counting down from `cpu_len` to 1.
- R3: A processor write (`cpu_write`=1) is accepted only with `cpu_len`=1. Any other processor length (a write not equal to 1, or a read that is neither 1 nor 8) raises `cpu_rej` instead of `cpu_ack`, and no beat follows.
- R4: Processor requests have strict priority. While a processor transfer has beats left, `gnt_dma` stays 0. When both requesters are accepted in the same cycle, the processor beats come first.
- R5: A DMA transfer issues `dma_sectors` × `cfg_sector_words` beats with `gnt_dma`=1. The beats are at consecutive word addresses from `dma_addr`, and `cmd_len` counts down to 1. The sector length is taken from `cfg_sector_words` when the request is accepted.
- R6: While `dma_pause` is 1 and no DMA beat is held, no DMA beat is offered. When `dma_pause` returns to 0, the next beat is the first word not yet taken.
- R7: A processor request accepted during a DMA transfer, running or paused, is served next. Once it completes, the DMA transfer continues from the first word not yet taken, with its remaining count.
- R8: An offered beat that is not taken (`seq_ready`=0) keeps its grant, address, direction and length until taken, even if `dma_pause` rises. `cpu_ack` stays 0 until that beat is taken. The processor is granted in the cycle after its acknowledge.
- R9: A DMA request is acknowledged in the cycle the last beat of the current DMA transfer is taken. The first beat of the new transfer is offered in the next cycle.
- R10: At most one of `gnt_cpu` and `gnt_dma` is 1. `cmd_valid` is 1 exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sector_words | input | SEC_W | Words per sector for DMA transfers |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` or `cpu_rej` |
| cpu_addr | input | ADDR_W | Processor start word address |
| cpu_write | input | 1 | Processor direction, 1 = write |
| cpu_len | input | CPU_LEN_W | Processor burst length in words |
| cpu_ack | output | 1 | Processor request accepted this cycle |
| cpu_rej | output | 1 | Processor request refused this cycle (illegal length) |
| dma_req | input | 1 | DMA request, held until `dma_ack` |
| dma_addr | input | ADDR_W | DMA start word address |
| dma_write | input | 1 | DMA direction, 1 = write |
| dma_sectors | input | SCNT_W | DMA transfer length in sectors |
| dma_pause | input | 1 | DMA data not available; hold further DMA beats |
| dma_ack | output | 1 | DMA request accepted this cycle |
| seq_ready | input | 1 | Sequencer takes the offered beat |
| cmd_valid | output | 1 | A beat is offered |
| gnt_cpu | output | 1 | The offered beat belongs to the processor |
| gnt_dma | output | 1 | The offered beat belongs to the DMA requester |
| cmd_addr | output | ADDR_W | Word address of the offered beat |
| cmd_write | output | 1 | Direction of the offered beat |
| cmd_len | output | SEC_W+SCNT_W | Words left in the current transfer, this beat included |

## Verification
The bench preempts a DMA transfer on its third beat and checks that the remaining words come out afterwards with unbroken addresses and counts. A design that reloaded or skipped the saved position would break the address sequence. It also preempts a paused transfer and releases the pause after the processor finishes. Here a wrong design would either let a DMA beat through while paused or lose its place. A third test holds a DMA beat with the sequencer not ready while a processor request and a pause arrive together. An arbiter that dropped or switched the held beat, or acknowledged the processor too early, shows up as a changed beat or a stray acknowledge. Chaining is checked by acknowledging the next DMA request only on the last beat and then expecting no empty cycle. Illegal processor lengths, which a loose decoder would turn into beats, are checked too.

// File: rtl/pri_mem_arb_pkg.sv
package pri_mem_arb_pkg;
   // owner of the offered beat
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_CPU  = 2'd1,
      OWN_DMA  = 2'd2
   } owner_e;

   // legal processor burst lengths
   localparam int unsigned CPU_RD_SHORT = 1;
   localparam int unsigned CPU_RD_LONG  = 8;
   localparam int unsigned CPU_WR_LEN   = 1;
endpackage

// File: rtl/pri_mem_arb_cpu.sv
module pri_mem_arb_cpu
   import pri_mem_arb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned CPU_LEN_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 wr_i,
   input  logic [CPU_LEN_W-1:0] len_i,
   input  logic                 take_ok_i,
   input  logic                 ready_i,
   output logic                 ack_o,
   output logic                 rej_o,
   output logic                 busy_o,
   output logic [ADDR_W-1:0]    addr_o,
   output logic                 wr_o,
   output logic [CPU_LEN_W-1:0] left_o
);
   localparam logic [CPU_LEN_W-1:0] ONE  = CPU_LEN_W'(1);
   localparam logic [CPU_LEN_W-1:0] LEN1 = CPU_LEN_W'(CPU_RD_SHORT);
   localparam logic [CPU_LEN_W-1:0] LEN8 = CPU_LEN_W'(CPU_RD_LONG);
   localparam logic [CPU_LEN_W-1:0] LENW = CPU_LEN_W'(CPU_WR_LEN);

   logic                 busy_q;
   logic [ADDR_W-1:0]    addr_q;
   logic                 wr_q;
   logic [CPU_LEN_W-1:0] left_q;
   logic                 legal;
   logic                 offer;
   logic                 fire;

   always_comb begin
      if (wr_i) legal = (len_i == LENW);
      else      legal = (len_i == LEN1) || (len_i == LEN8);
   end

   assign offer = req_i && !busy_q && take_ok_i;
   assign ack_o = offer && legal;
   assign rej_o = offer && !legal;
   assign fire  = busy_q && ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         wr_q   <= 1'b0;
         left_q <= '0;
      end else if (ack_o) begin
         busy_q <= 1'b1;
         addr_q <= addr_i;
         wr_q   <= wr_i;
         left_q <= len_i;
      end else if (fire) begin
         addr_q <= addr_q + ADDR_W'(1);
         left_q <= left_q - ONE;
         if (left_q == ONE) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign addr_o = addr_q;
   assign wr_o   = wr_q;
   assign left_o = left_q;

   // R2: an active processor burst always has words left
   p_left_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (left_q != '0));
   // R3: a refused request starts no burst
   p_rej_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rej_o |=> !busy_q);
   // R2: each taken beat advances the address by one word
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && left_q != ONE) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/pri_mem_arb_dma.sv
module pri_mem_arb_dma #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned SEC_W  = 8,
   parameter int unsigned SCNT_W = 8,
   localparam int unsigned LEN_W = SEC_W + SCNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [SCNT_W-1:0] sectors_i,
   input  logic [SEC_W-1:0]  sec_words_i,
   input  logic              pause_i,
   input  logic              cpu_busy_i,
   input  logic              ready_i,
   output logic              ack_o,
   output logic              go_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_o,
   output logic [LEN_W-1:0]  left_o
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic              active_q;
   logic              hold_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [LEN_W-1:0]  left_q;
   logic [LEN_W-1:0]  total;
   logic              fire;
   logic              last_fire;

   assign total     = LEN_W'(sectors_i) * LEN_W'(sec_words_i);
   // a beat already offered is kept even when pause rises
   assign go_o      = active_q && !cpu_busy_i && (!pause_i || hold_q);
   assign fire      = go_o && ready_i;
   assign last_fire = fire && (left_q == ONE);
   assign ack_o     = req_i && (!active_q || last_fire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hold_q   <= 1'b0;
         addr_q   <= '0;
         wr_q     <= 1'b0;
         left_q   <= '0;
      end else begin
         hold_q <= go_o && !ready_i;
         if (ack_o) begin
            active_q <= (total != '0);
            addr_q   <= addr_i;
            wr_q     <= wr_i;
            left_q   <= total;
         end else if (fire) begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - ONE;
            if (left_q == ONE) active_q <= 1'b0;
         end
      end
   end

   assign addr_o = addr_q;
   assign wr_o   = wr_q;
   assign left_o = left_q;

   // R5: each taken beat steps address up and count down by one
   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && left_q != ONE) |=>
         (addr_q == $past(addr_q) + ADDR_W'(1)) && (left_q == $past(left_q) - ONE));
   // R7: position is frozen while the processor owns the path
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_busy_i && active_q && !ack_o) |=> ($stable(addr_q) && $stable(left_q)));
   // R9: a request taken on the last beat leaves the port active
   p_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (last_fire && req_i && total != '0) |=> active_q);
endmodule

// File: rtl/pri_mem_arb.sv
module pri_mem_arb
   import pri_mem_arb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned SEC_W     = 8,
   parameter int unsigned SCNT_W    = 8,
   parameter int unsigned CPU_LEN_W = 4,
   localparam int unsigned LEN_W    = SEC_W + SCNT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEC_W-1:0]     cfg_sector_words,
   input  logic                 cpu_req,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic                 cpu_write,
   input  logic [CPU_LEN_W-1:0] cpu_len,
   output logic                 cpu_ack,
   output logic                 cpu_rej,
   input  logic                 dma_req,
   input  logic [ADDR_W-1:0]    dma_addr,
   input  logic                 dma_write,
   input  logic [SCNT_W-1:0]    dma_sectors,
   input  logic                 dma_pause,
   output logic                 dma_ack,
   input  logic                 seq_ready,
   output logic                 cmd_valid,
   output logic                 gnt_cpu,
   output logic                 gnt_dma,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic                 cmd_write,
   output logic [LEN_W-1:0]     cmd_len
);
   // elaboration-time parameter checks
   generate
      if (CPU_LEN_W < 4) begin : g_bad_cpu_len
         $error("CPU_LEN_W must hold the value 8");
      end
      if (LEN_W <= CPU_LEN_W) begin : g_bad_len
         $error("DMA length field must be wider than the processor length");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   logic                 take_ok;
   logic                 cpu_busy;
   logic [ADDR_W-1:0]    cpu_cur_addr;
   logic                 cpu_cur_wr;
   logic [CPU_LEN_W-1:0] cpu_left;
   logic                 dma_go;
   logic [ADDR_W-1:0]    dma_cur_addr;
   logic                 dma_cur_wr;
   logic [LEN_W-1:0]     dma_left;
   owner_e               owner;

   // no new processor burst while an offered beat waits
   assign take_ok = !(cmd_valid && !seq_ready);

   pri_mem_arb_cpu #(
      .ADDR_W    (ADDR_W),
      .CPU_LEN_W (CPU_LEN_W)
   ) u_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (cpu_req),
      .addr_i    (cpu_addr),
      .wr_i      (cpu_write),
      .len_i     (cpu_len),
      .take_ok_i (take_ok),
      .ready_i   (seq_ready),
      .ack_o     (cpu_ack),
      .rej_o     (cpu_rej),
      .busy_o    (cpu_busy),
      .addr_o    (cpu_cur_addr),
      .wr_o      (cpu_cur_wr),
      .left_o    (cpu_left)
   );

   pri_mem_arb_dma #(
      .ADDR_W (ADDR_W),
      .SEC_W  (SEC_W),
      .SCNT_W (SCNT_W)
   ) u_dma (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (dma_req),
      .addr_i      (dma_addr),
      .wr_i        (dma_write),
      .sectors_i   (dma_sectors),
      .sec_words_i (cfg_sector_words),
      .pause_i     (dma_pause),
      .cpu_busy_i  (cpu_busy),
      .ready_i     (seq_ready),
      .ack_o       (dma_ack),
      .go_o        (dma_go),
      .addr_o      (dma_cur_addr),
      .wr_o        (dma_cur_wr),
      .left_o      (dma_left)
   );

   always_comb begin
      if (cpu_busy)    owner = OWN_CPU;
      else if (dma_go) owner = OWN_DMA;
      else             owner = OWN_NONE;
   end

   always_comb begin
      gnt_cpu   = 1'b0;
      gnt_dma   = 1'b0;
      cmd_addr  = '0;
      cmd_write = 1'b0;
      cmd_len   = '0;
      unique case (owner)
         OWN_CPU: begin
            gnt_cpu   = 1'b1;
            cmd_addr  = cpu_cur_addr;
            cmd_write = cpu_cur_wr;
            cmd_len   = LEN_W'(cpu_left);
         end
         OWN_DMA: begin
            gnt_dma   = 1'b1;
            cmd_addr  = dma_cur_addr;
            cmd_write = dma_cur_wr;
            cmd_len   = dma_left;
         end
         default: ;
      endcase
   end

   assign cmd_valid = gnt_cpu | gnt_dma;

   // R10: grants never overlap
   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_cpu, gnt_dma}));
   // R4 / R8: an accepted processor request owns the next beat
   p_cpu_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> (gnt_cpu && !gnt_dma));
   // R8: an untaken beat is held unchanged
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !seq_ready) |=>
         (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
          && $stable(gnt_cpu) && $stable(cmd_write)));
   // R3: accept and refuse are exclusive
   p_ack_rej_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_ack && cpu_rej));
endmodule

// File: tb/pri_mem_arb_tb.sv
`timescale 1ns/1ps
module pri_mem_arb_tb;
   localparam int ADDR_W = 24;
   localparam int SEC_W  = 8;
   localparam int SCNT_W = 8;
   localparam int CLW    = 4;
   localparam int LEN_W  = SEC_W + SCNT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [SEC_W-1:0]  cfg_sector_words = 8'd4;
   logic              cpu_req = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic              cpu_write = 1'b0;
   logic [CLW-1:0]    cpu_len = '0;
   logic              cpu_ack, cpu_rej;
   logic              dma_req = 1'b0;
   logic [ADDR_W-1:0] dma_addr = '0;
   logic              dma_write = 1'b0;
   logic [SCNT_W-1:0] dma_sectors = '0;
   logic              dma_pause = 1'b0;
   logic              dma_ack;
   logic              seq_ready = 1'b1;
   logic              cmd_valid, gnt_cpu, gnt_dma, cmd_write;
   logic [ADDR_W-1:0] cmd_addr;
   logic [LEN_W-1:0]  cmd_len;

   always #2.5 clk = ~clk;

   pri_mem_arb #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .SCNT_W(SCNT_W), .CPU_LEN_W(CLW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_sector_words(cfg_sector_words),
      .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_write(cpu_write), .cpu_len(cpu_len),
      .cpu_ack(cpu_ack), .cpu_rej(cpu_rej),
      .dma_req(dma_req), .dma_addr(dma_addr), .dma_write(dma_write),
      .dma_sectors(dma_sectors), .dma_pause(dma_pause), .dma_ack(dma_ack),
      .seq_ready(seq_ready), .cmd_valid(cmd_valid), .gnt_cpu(gnt_cpu), .gnt_dma(gnt_dma),
      .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_len(cmd_len));

   typedef struct {
      bit        is_cpu;
      int        addr;
      bit        wr;
      int        len;
      string     tag;
   } beat_t;

   beat_t exp_q[$];
   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver side: expected beats
   task automatic push_cpu(input int addr, input bit wr, input int len, input string tag);
      for (int i = 0; i < len; i++) begin
         beat_t b;
         b.is_cpu = 1'b1; b.addr = addr + i; b.wr = wr; b.len = len - i; b.tag = tag;
         exp_q.push_back(b);
      end
   endtask

   task automatic push_dma(input int addr, input bit wr, input int total,
                           input int first, input int count, input string tag);
      for (int i = first; i < first + count; i++) begin
         beat_t b;
         b.is_cpu = 1'b0; b.addr = addr + i; b.wr = wr; b.len = total - i; b.tag = tag;
         exp_q.push_back(b);
      end
   endtask

   // monitor: compare every taken beat with the queue head
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(!(gnt_cpu && gnt_dma) && (cmd_valid == (gnt_cpu | gnt_dma)),
               "R10 grant exclusive", {gnt_cpu, gnt_dma}, 0);
         if (cmd_valid && seq_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "unexpected beat", int'(cmd_addr), 0);
            end else begin
               beat_t b;
               b = exp_q.pop_front();
               check(gnt_cpu == b.is_cpu, {b.tag, " owner"}, gnt_cpu, b.is_cpu);
               check(int'(cmd_addr) == b.addr, {b.tag, " addr"}, int'(cmd_addr), b.addr);
               check(cmd_write == b.wr, {b.tag, " dir"}, cmd_write, b.wr);
               check(int'(cmd_len) == b.len, {b.tag, " len"}, int'(cmd_len), b.len);
            end
         end
      end
   end

   task automatic drain(input string tag);
      int k = 0;
      while ((exp_q.size() != 0 || cmd_valid) && k < 300) begin
         @(negedge clk); #3; k++;
      end
      check(exp_q.size() == 0, {tag, " all beats seen"}, exp_q.size(), 0);
      @(negedge clk);
   endtask

   task automatic start_dma(input int addr, input bit wr, input int secs);
      dma_req = 1'b1; dma_addr = ADDR_W'(addr); dma_write = wr; dma_sectors = SCNT_W'(secs);
   endtask

   task automatic start_cpu(input int addr, input bit wr, input int len);
      cpu_req = 1'b1; cpu_addr = ADDR_W'(addr); cpu_write = wr; cpu_len = CLW'(len);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      check(!cmd_valid && !gnt_cpu && !gnt_dma, "R1 idle in reset", cmd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!cmd_valid && !gnt_cpu && !gnt_dma, "R1 idle after reset", cmd_valid, 0);
      check(!cpu_ack && !cpu_rej && !dma_ack, "R1 no acks", {cpu_ack, cpu_rej, dma_ack}, 0);

      // R2: eight-word processor read
      @(negedge clk);
      push_cpu('h100, 1'b0, 8, "R2 rd8");
      start_cpu('h100, 1'b0, 8); #1;
      check(cpu_ack && !cpu_rej, "R2 rd8 ack", cpu_ack, 1);
      @(negedge clk); cpu_req = 1'b0;
      drain("R2 rd8");

      // R2 one-word read, R3 one-word write
      push_cpu('h120, 1'b0, 1, "R2 rd1");
      start_cpu('h120, 1'b0, 1); #1;
      check(cpu_ack, "R2 rd1 ack", cpu_ack, 1);
      @(negedge clk); cpu_req = 1'b0;
      drain("R2 rd1");
      push_cpu('h130, 1'b1, 1, "R3 wr1");
      start_cpu('h130, 1'b1, 1); #1;
      check(cpu_ack, "R3 wr1 ack", cpu_ack, 1);
      @(negedge clk); cpu_req = 1'b0;
      drain("R3 wr1");

      // R3: illegal lengths are refused
      start_cpu('h140, 1'b1, 8); #1;
      check(cpu_rej && !cpu_ack, "R3 wr8 refused", cpu_rej, 1);
      @(negedge clk); start_cpu('h140, 1'b0, 4); #1;
      check(cpu_rej && !cpu_ack, "R3 rd4 refused", cpu_rej, 1);
      @(negedge clk); cpu_req = 1'b0; #1;
      check(!cmd_valid, "R3 no beat after refuse", cmd_valid, 0);
      @(negedge clk); #1;
      check(!cmd_valid, "R3 still idle", cmd_valid, 0);

      // R5: 2 sectors of 4 words
      push_dma('h200, 1'b1, 8, 0, 8, "R5 dma 2x4");
      start_dma('h200, 1'b1, 2); #1;
      check(dma_ack, "R5 dma ack", dma_ack, 1);
      @(negedge clk); dma_req = 1'b0;
      drain("R5 2x4");

      // R5: programmed sector length 3, 3 sectors
      cfg_sector_words = 8'd3;
      push_dma('h220, 1'b0, 9, 0, 9, "R5 dma 3x3");
      start_dma('h220, 1'b0, 3); #1;
      check(dma_ack, "R5 dma 3x3 ack", dma_ack, 1);
      @(negedge clk); dma_req = 1'b0;
      drain("R5 3x3");
      cfg_sector_words = 8'd4;

      // R7 / R4: preempt a running DMA transfer
      push_dma('h300, 1'b0, 8, 0, 3, "R7 run pre");
      push_cpu('h80, 1'b0, 8, "R4 cpu over dma");
      push_dma('h300, 1'b0, 8, 3, 5, "R7 run resume");
      start_dma('h300, 1'b0, 2); #1;
      check(dma_ack, "R7 dma ack", dma_ack, 1);
      @(negedge clk); dma_req = 1'b0;
      @(negedge clk);
      @(negedge clk); start_cpu('h80, 1'b0, 8); #1;
      check(cpu_ack, "R7 cpu ack while running", cpu_ack, 1);
      @(negedge clk); cpu_req = 1'b0;
      drain("R7 running");

      // R6 / R7: pause mid-sector, preempt while paused
      push_dma('h400, 1'b1, 8, 0, 2, "R6 pre pause");
      push_cpu('h90, 1'b0, 1, "R7 cpu while paused");
      push_dma('h400, 1'b1, 8, 2, 6, "R6 resume");
      start_dma('h400, 1'b1, 2); #1;
      @(negedge clk); dma_req = 1'b0;
      @(negedge clk);
      @(negedge clk); dma_pause = 1'b1; #1;
      check(!cmd_valid, "R6 paused no beat", cmd_valid, 0);
      @(negedge clk); #1;
      check(!cmd_valid, "R6 still paused", cmd_valid, 0);
      start_cpu('h90, 1'b0, 1); #1;
      check(cpu_ack, "R7 cpu ack while paused", cpu_ack, 1);
      @(negedge clk); cpu_req = 1'b0; #1;
      check(gnt_cpu, "R7 cpu granted", gnt_cpu, 1);
      @(negedge clk); #1;
      check(!cmd_valid, "R6 paused after cpu", cmd_valid, 0);
      dma_pause = 1'b0; #1;
      check(gnt_dma && int'(cmd_addr) == 'h402, "R6 resume addr", int'(cmd_addr), 'h402);
      drain("R6 pause");

      // R8: held beat with processor request and pause
      push_dma('h500, 1'b0, 4, 0, 1, "R8 held");
      push_cpu('hA0, 1'b0, 1, "R8 cpu after hold");
      push_dma('h500, 1'b0, 4, 1, 3, "R8 rest");
      start_dma('h500, 1'b0, 1); #1;
      @(negedge clk); dma_req = 1'b0; seq_ready = 1'b0;
      start_cpu('hA0, 1'b0, 1); #1;
      check(!cpu_ack, "R8 cpu waits for held beat", cpu_ack, 0);
      @(negedge clk); dma_pause = 1'b1; #1;
      check(!cpu_ack, "R8 cpu still waits", cpu_ack, 0);
      check(gnt_dma && int'(cmd_addr) == 'h500 && int'(cmd_len) == 4,
            "R8 beat held under pause", int'(cmd_addr), 'h500);
      @(negedge clk); seq_ready = 1'b1; #1;
      check(cpu_ack, "R8 cpu ack when taken", cpu_ack, 1);
      @(negedge clk); cpu_req = 1'b0; dma_pause = 1'b0; #1;
      check(gnt_cpu, "R8 cpu granted next cycle", gnt_cpu, 1);
      drain("R8 hold");

      // R9: chained DMA transfers, no gap
      push_dma('h600, 1'b0, 4, 0, 4, "R9 first");
      push_dma('h700, 1'b0, 4, 0, 4, "R9 second");
      start_dma('h600, 1'b0, 1); #1;
      check(dma_ack, "R9 first ack", dma_ack, 1);
      @(negedge clk); start_dma('h700, 1'b0, 1); #1;
      begin
         int k = 0;
         while (!dma_ack && k < 20) begin
            @(negedge clk); #1; k++;
         end
      end
      check(dma_ack && gnt_dma && int'(cmd_len) == 1, "R9 ack on last beat",
            int'(cmd_len), 1);
      @(negedge clk); dma_req = 1'b0; #1;
      check(gnt_dma && int'(cmd_addr) == 'h700, "R9 no idle cycle", int'(cmd_addr), 'h700);
      drain("R9 chain");

      // R4: simultaneous requests, processor first
      push_cpu('hB0, 1'b0, 8, "R4 cpu first");
      push_dma('h800, 1'b1, 4, 0, 4, "R4 dma after");
      start_cpu('hB0, 1'b0, 8); start_dma('h800, 1'b1, 1); #1;
      check(cpu_ack && dma_ack, "R4 both accepted", {cpu_ack, dma_ack}, 3);
      @(negedge clk); cpu_req = 1'b0; dma_req = 1'b0; #1;
      check(gnt_cpu && !gnt_dma, "R4 cpu wins", gnt_cpu, 1);
      drain("R4 both");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule